// File: doc/BRIEF.md
# Banked System Control Register File

This block is a small register file in the system control space. Each access carries a security attribute. Some registers keep one copy for secure accesses and one for non-secure accesses, and the attribute of the access picks the copy that is read or written. The banked registers are the sleep/system-control register and the cache-size selection register.

A read of the cache geometry register is indirect. It returns the table entry chosen by the selection index of the bank that made the access. The table is computed from two parameters. The identification values are parameter constants, and writes to them are ignored. Cache and branch-predictor maintenance writes are accepted and do nothing. The interrupt control/state word holds the set and clear bits for the non-maskable-interrupt request. The block drives that request on an output and does not deliver it.

Each request is sampled on a clock edge. Its read data and error flag are registered and valid for the one cycle that follows. Writes update state on the same edge.

Top module: `sysctl_bank_regs`

## Requirements
- R1: After reset `nmi_pend`, `rsp_rdata` and `rsp_err` are 0. Both copies of the system-control register and both copies of the selection register are 0.
- R2: The response to a request sampled at edge N is valid from edge N until edge N+1. A write returns read data 0. A cycle with no request gives `rsp_rdata`=0 and `rsp_err`=0.
- R3: The system-control register is at offset 0xD10 and has one copy per security state. A write stores only bits 1 and 4 into the copy chosen by `req_secure`. A read returns that copy, and all other bits read 0.
- R4: Bits 2 and 3 of the system-control register always read 0, and writes to them are ignored.
- R5: The selection register is at offset 0xD84 and is banked. A write stores only bits [3:0] of the write data. When `NUM_CACHES`=0, writes to it are ignored.
- R6: A read of offset 0xD80 returns `CCS_BASE + idx*CCS_STEP`, where idx is the selection index of the accessing bank. Writes to 0xD80 are ignored.
- R7: Offsets 0xD40, 0xD78 and 0xD7C read the constants `ID_FEAT0`, `ID_CLVL` and `ID_CTYPE`. Writes to them are ignored and raise no error.
- R8: When `V8_EN`=1, offset 0x00C reads 0, ignores writes and raises no error. When `V8_EN`=0, offset 0x00C is unmapped.
- R9: Writes to 0xF50 and to every word offset from 0xF58 to 0xF78 are accepted without error and change no state. Offsets 0xF54 and 0xF7C are unmapped.
- R10: Offset 0xD04 controls the NMI request. Write bit 31 sets the request, and write bit 30 clears it. If both bits are 1, the set wins. A read returns the request in bit 31 and 0 in all other bits.
- R11: An access to 0xD04 acts on the NMI request only if `req_secure`=1 or `cfg_ns_nmi`=1. Otherwise its writes have no effect and its reads return 0.
- R12: An access to any offset not listed above returns `rsp_rdata`=0 with `rsp_err`=1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ns_nmi | input | 1 | Grants non-secure accesses control of the NMI request |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the access; selects the bank |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_err | output | 1 | Error response, one cycle after the request |
| nmi_pend | output | 1 | Pending NMI request |

## Verification
Every response comes from one register stage. The bench drives a request on the falling edge and samples `rsp_rdata` and `rsp_err` one time unit after the next rising edge. It removes the request at the following falling edge, before the response register reloads.

Banked state and the NMI request change on that same rising edge. The effect of a write is seen through `nmi_pend` at the same sampling point, or through a read on the next access. A second instance with no caches and the older architecture option runs on the same bus. It shows the ignored selection writes and the invalid 0x00C offset.

// File: rtl/sysctl_bank_regs.sv
module sysctl_bank_regs #(
  parameter bit          V8_EN      = 1'b1,
  parameter int          NUM_CACHES = 2,
  parameter int          IDX_W      = 4,
  parameter logic [31:0] ID_FEAT0   = 32'h0000_0030,
  parameter logic [31:0] ID_CLVL    = 32'h0900_0003,
  parameter logic [31:0] ID_CTYPE   = 32'h8303_C003,
  parameter logic [31:0] CCS_BASE   = 32'hF003_E019,
  parameter logic [31:0] CCS_STEP   = 32'h0000_2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_ns_nmi,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_secure,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        nmi_pend
);
  localparam logic [11:0] OFF_PWR  = 12'h00C;
  localparam logic [11:0] OFF_ICSR = 12'hD04;
  localparam logic [11:0] OFF_SCR  = 12'hD10;
  localparam logic [11:0] OFF_FT0  = 12'hD40;
  localparam logic [11:0] OFF_CLV  = 12'hD78;
  localparam logic [11:0] OFF_CTY  = 12'hD7C;
  localparam logic [11:0] OFF_CCS  = 12'hD80;
  localparam logic [11:0] OFF_CSEL = 12'hD84;
  localparam logic [31:0] SCR_KEEP = 32'h0000_0012;
  localparam bit          CSEL_WE  = (NUM_CACHES > 0);

  logic [31:0]      scr_q  [2];
  logic [IDX_W-1:0] csel_q [2];
  logic             nmi_q;
  logic [31:0]      rd_d, rdata_q;
  logic             hit_d, err_q;

  wire bank   = req_secure;
  wire nmi_ok = req_secure | cfg_ns_nmi;
  wire wr     = req_valid & req_write;
  wire maint  = (req_addr == 12'hF50) ||
                (req_addr >= 12'hF58 && req_addr <= 12'hF78 && req_addr[1:0] == 2'b00);
  wire [31:0] ccs_val = CCS_BASE + CCS_STEP * 32'(csel_q[bank]);

  always_comb begin
    rd_d  = '0;
    hit_d = 1'b1;
    case (req_addr)
      OFF_PWR:  hit_d = V8_EN;
      OFF_ICSR: rd_d  = {nmi_ok & nmi_q, 31'b0};
      OFF_SCR:  rd_d  = scr_q[bank];
      OFF_FT0:  rd_d  = ID_FEAT0;
      OFF_CLV:  rd_d  = ID_CLVL;
      OFF_CTY:  rd_d  = ID_CTYPE;
      OFF_CCS:  rd_d  = ccs_val;
      OFF_CSEL: rd_d  = 32'(csel_q[bank]);
      default:  hit_d = maint;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q[0]  <= '0;
      scr_q[1]  <= '0;
      csel_q[0] <= '0;
      csel_q[1] <= '0;
      nmi_q     <= 1'b0;
    end else if (wr) begin
      if (req_addr == OFF_SCR)
        scr_q[bank] <= req_wdata & SCR_KEEP;
      if (req_addr == OFF_CSEL && CSEL_WE)
        csel_q[bank] <= req_wdata[IDX_W-1:0];
      if (req_addr == OFF_ICSR && nmi_ok) begin
        if (req_wdata[31])      nmi_q <= 1'b1;
        else if (req_wdata[30]) nmi_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (req_valid && !req_write && hit_d) ? rd_d : '0;
      err_q   <= req_valid && !hit_d;
    end
  end

  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;
  assign nmi_pend  = nmi_q;
endmodule

// File: rtl/sysctl_bank_regs_chk.sv
module sysctl_bank_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_ns_nmi,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_secure,
  input logic [11:0] req_addr,
  input logic [31:0] req_wdata,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err,
  input logic        nmi_pend
);
  wire icsr_wr = req_valid && req_write && req_addr == 12'hD04;
  wire maint_wr = req_valid && req_write &&
                  (req_addr == 12'hF50 ||
                   (req_addr >= 12'hF58 && req_addr <= 12'hF78 && req_addr[1:0] == 2'b00));

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (rsp_rdata == 32'h0 && !rsp_err)); // R2

  AST_SCR_DEEP_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 12'hD10) |=> rsp_rdata[3:2] == 2'b00); // R4

  AST_MAINT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    maint_wr |=> !rsp_err); // R9

  AST_NMI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (icsr_wr && (req_secure || cfg_ns_nmi) && req_wdata[31]) |=> nmi_pend); // R10

  AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (icsr_wr && !req_secure && !cfg_ns_nmi) |=> $stable(nmi_pend)); // R11

  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == 12'h100) |=> (rsp_err && rsp_rdata == 32'h0)); // R12
endmodule

bind sysctl_bank_regs sysctl_bank_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ns_nmi(cfg_ns_nmi), .req_valid(req_valid),
  .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .nmi_pend(nmi_pend)
);

// File: tb/test_sysctl_bank_regs.sv
module test_sysctl_bank_regs;
  localparam logic [31:0] F0 = 32'h0000_0030;
  localparam logic [31:0] CL = 32'h0900_0003;
  localparam logic [31:0] CT = 32'h8303_C003;
  localparam logic [31:0] CB = 32'hF003_E019;
  localparam logic [31:0] CS = 32'h0000_2000;
  localparam logic [31:0] C5 = 32'(CB + 32'd5 * CS);
  localparam int NV = 39;

  // {req#, write, secure, addr, wdata, exp_rdata, exp_err}
  localparam logic [82:0] VEC [NV] = '{
    {4'd3,  1'b0,1'b1,12'hD10,32'h0,        32'h0,        1'b0},
    {4'd3,  1'b1,1'b1,12'hD10,32'hFFFF_FFFF,32'h0,        1'b0},
    {4'd4,  1'b0,1'b1,12'hD10,32'h0,        32'h12,       1'b0}, // R4
    {4'd3,  1'b0,1'b0,12'hD10,32'h0,        32'h0,        1'b0}, // R3 bank
    {4'd3,  1'b1,1'b0,12'hD10,32'h1E,       32'h0,        1'b0},
    {4'd3,  1'b0,1'b0,12'hD10,32'h0,        32'h12,       1'b0},
    {4'd4,  1'b1,1'b0,12'hD10,32'h0C,       32'h0,        1'b0},
    {4'd4,  1'b0,1'b0,12'hD10,32'h0,        32'h0,        1'b0},
    {4'd5,  1'b1,1'b1,12'hD84,32'hFFFF_FFF5,32'h0,        1'b0},
    {4'd5,  1'b0,1'b1,12'hD84,32'h0,        32'h5,        1'b0}, // R5
    {4'd5,  1'b0,1'b0,12'hD84,32'h0,        32'h0,        1'b0},
    {4'd6,  1'b0,1'b1,12'hD80,32'h0,        C5,           1'b0}, // R6
    {4'd6,  1'b0,1'b0,12'hD80,32'h0,        CB,           1'b0},
    {4'd6,  1'b1,1'b1,12'hD80,32'h0,        32'h0,        1'b0},
    {4'd6,  1'b0,1'b1,12'hD80,32'h0,        C5,           1'b0},
    {4'd7,  1'b0,1'b1,12'hD40,32'h0,        F0,           1'b0}, // R7
    {4'd7,  1'b1,1'b0,12'hD40,32'h0,        32'h0,        1'b0},
    {4'd7,  1'b0,1'b0,12'hD40,32'h0,        F0,           1'b0},
    {4'd7,  1'b0,1'b1,12'hD78,32'h0,        CL,           1'b0},
    {4'd7,  1'b0,1'b1,12'hD7C,32'h0,        CT,           1'b0},
    {4'd8,  1'b0,1'b0,12'h00C,32'h0,        32'h0,        1'b0}, // R8
    {4'd8,  1'b1,1'b1,12'h00C,32'hFFFF_FFFF,32'h0,        1'b0},
    {4'd8,  1'b0,1'b1,12'h00C,32'h0,        32'h0,        1'b0},
    {4'd9,  1'b1,1'b1,12'hF50,32'h0,        32'h0,        1'b0}, // R9
    {4'd9,  1'b1,1'b0,12'hF78,32'h0,        32'h0,        1'b0},
    {4'd9,  1'b1,1'b1,12'hF54,32'h0,        32'h0,        1'b1},
    {4'd9,  1'b1,1'b1,12'hF7C,32'h0,        32'h0,        1'b1},
    {4'd12, 1'b0,1'b1,12'h100,32'h0,        32'h0,        1'b1}, // R12
    {4'd11, 1'b1,1'b0,12'hD04,32'h8000_0000,32'h0,        1'b0}, // R11
    {4'd11, 1'b0,1'b1,12'hD04,32'h0,        32'h0,        1'b0},
    {4'd10, 1'b1,1'b1,12'hD04,32'h8000_0000,32'h0,        1'b0}, // R10
    {4'd10, 1'b0,1'b1,12'hD04,32'h0,        32'h8000_0000,1'b0},
    {4'd11, 1'b0,1'b0,12'hD04,32'h0,        32'h0,        1'b0},
    {4'd11, 1'b1,1'b0,12'hD04,32'h4000_0000,32'h0,        1'b0},
    {4'd11, 1'b0,1'b1,12'hD04,32'h0,        32'h8000_0000,1'b0},
    {4'd10, 1'b1,1'b1,12'hD04,32'hC000_0000,32'h0,        1'b0},
    {4'd10, 1'b0,1'b1,12'hD04,32'h0,        32'h8000_0000,1'b0},
    {4'd10, 1'b1,1'b1,12'hD04,32'h4000_0000,32'h0,        1'b0},
    {4'd10, 1'b0,1'b1,12'hD04,32'h0,        32'h0,        1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_ns_nmi = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic err_a, err_b, nmi_a, nmi_b;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sysctl_bank_regs #(.V8_EN(1'b1), .NUM_CACHES(2), .IDX_W(4), .ID_FEAT0(F0),
    .ID_CLVL(CL), .ID_CTYPE(CT), .CCS_BASE(CB), .CCS_STEP(CS)) i_sysctl_bank_regs (
    .clk(clk), .rst_n(rst_n), .cfg_ns_nmi(cfg_ns_nmi), .req_valid(req_valid),
    .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rd_a), .rsp_err(err_a), .nmi_pend(nmi_a));

  sysctl_bank_regs #(.V8_EN(1'b0), .NUM_CACHES(0), .IDX_W(4), .ID_FEAT0(F0),
    .ID_CLVL(CL), .ID_CTYPE(CT), .CCS_BASE(CB), .CCS_STEP(CS)) i_sysctl_bank_regs_min (
    .clk(clk), .rst_n(rst_n), .cfg_ns_nmi(cfg_ns_nmi), .req_valid(req_valid),
    .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rd_b), .rsp_err(err_b), .nmi_pend(nmi_b));

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic s, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_secure = s; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // sample window sits between the posedge after the request and the next negedge
  task automatic access_s(input logic w, input logic s, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_secure = s; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rsp", {err_a, rd_a}, 33'h0);
    chk("R1 reset nmi", {32'h0, nmi_a}, 33'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R2 idle rsp", {err_a, rd_a}, 33'h0);

    for (int i = 0; i < NV; i++) begin
      access_s(VEC[i][78], VEC[i][77], VEC[i][76:65], VEC[i][64:33]);
      checks++;
      if ({err_a, rd_a} !== {VEC[i][0], VEC[i][32:1]}) begin
        fails++;
        $display("FAIL R%0d vec %0d: got %h/%b expected %h/%b",
                 VEC[i][82:79], i, rd_a, err_a, VEC[i][32:1], VEC[i][0]);
      end
      @(negedge clk);
      req_valid = 1'b0;
    end

    // R2: response lasts one cycle
    @(posedge clk); #1;
    chk("R2 one-cycle rsp", {err_a, rd_a}, 33'h0);

    // R5: no caches configured, selection stays 0
    access_s(1'b1, 1'b1, 12'hD84, 32'h7);
    @(negedge clk); req_valid = 1'b0;
    access_s(1'b0, 1'b1, 12'hD84, 32'h0);
    chk("R5 min csel ignored", {err_b, rd_b}, 33'h0);
    chk("R5 main csel", {err_a, rd_a}, {1'b0, 32'h7});
    @(negedge clk); req_valid = 1'b0;
    access_s(1'b0, 1'b1, 12'hD80, 32'h0);
    chk("R6 min ccs idx0", {err_b, rd_b}, {1'b0, CB});
    chk("R6 main ccs idx7", {err_a, rd_a}, {1'b0, 32'(CB + 32'd7 * CS)});
    @(negedge clk); req_valid = 1'b0;

    // R8: older option -> 0x00C unmapped
    access_s(1'b0, 1'b1, 12'h00C, 32'h0);
    chk("R8 min pwr err", {err_b, rd_b}, {1'b1, 32'h0});
    chk("R8 main pwr ok", {err_a, rd_a}, 33'h0);
    @(negedge clk); req_valid = 1'b0;

    // R11: grant bit opens non-secure control
    cfg_ns_nmi = 1'b1;
    access_s(1'b1, 1'b0, 12'hD04, 32'h8000_0000);
    chk("R11 ns set nmi", {32'h0, nmi_a}, 33'h1);
    @(negedge clk); req_valid = 1'b0;
    access_s(1'b0, 1'b0, 12'hD04, 32'h0);
    chk("R11 ns read nmi", {err_a, rd_a}, {1'b0, 32'h8000_0000});
    @(negedge clk); req_valid = 1'b0;
    access_s(1'b1, 1'b0, 12'hD04, 32'h4000_0000);
    chk("R10 ns clear nmi", {32'h0, nmi_a}, 33'h0);
    @(negedge clk); req_valid = 1'b0;
    cfg_ns_nmi = 1'b0;

    // R9: maintenance writes leave banked state alone
    access(1'b1, 1'b1, 12'hF60, 32'hFFFF_FFFF);
    access_s(1'b0, 1'b1, 12'hD10, 32'h0);
    chk("R9 scr unchanged", {err_a, rd_a}, {1'b0, 32'h12});
    @(negedge clk); req_valid = 1'b0;

    // R1: reset clears banked state
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 reset nmi again", {32'h0, nmi_a}, 33'h0);
    @(negedge clk); rst_n = 1'b1;
    access_s(1'b0, 1'b0, 12'hD10, 32'h0);
    chk("R1 scr ns cleared", {err_a, rd_a}, 33'h0);
    @(negedge clk); req_valid = 1'b0;
    access_s(1'b0, 1'b1, 12'hD84, 32'h0);
    chk("R1 csel cleared", {err_a, rd_a}, 33'h0);
    @(negedge clk); req_valid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule